// File: doc/BRIEF.md
# Redundant Reference Clock Failover Selector

This block chooses which of two reference clocks, `clk_a` or `clk_b`, drives a single output clock. A configuration bit names one input as the primary, and the other input becomes the secondary. A two-bit mode field picks how the choice is made. In manual operation an external select pin chooses between the primary and the secondary. In automatic operation a watchdog clocked by the secondary monitors the primary. If the primary stops, the output fails over to the secondary. When the primary runs again, the output returns to it.

Automatic failover is only honoured while `clk_a` is the primary. In that case `clk_b` is the secondary and clocks the watchdog. If automatic mode is requested while `clk_b` is primary, the select pin keeps control exactly as in manual mode. The output stage is a break-before-make clock switch. Each input has its own enable, synchronized in that input's clock domain. An enable only rises after the other enable is seen low, so neither source is cut mid-phase. When the watchdog declares the primary dead, the primary's enable is cleared directly, because that clock can no longer do it. A status output shows which input is driving, and a sticky flag records that the primary was lost.

Top module: `refclk_failover_mux`

## Requirements
- R1: After reset `loss_flag` is 0, `act_b` is 0 and, with `prim_is_b`=0, `mode`=00 and `sel_sec`=0, `clk_out` runs at the `clk_a` period.
- R2: `prim_is_b`=0 makes `clk_a` the primary and `clk_b` the secondary; `prim_is_b`=1 swaps the roles.
- R3: With `mode[1]`=0 (manual), `sel_sec`=0 routes the primary to `clk_out` and `sel_sec`=1 routes the secondary.
- R4: With `mode[1]`=1 and `prim_is_b`=0, `sel_sec` has no effect while `clk_a` toggles, and `clk_out` follows `clk_a`. Once `clk_a` shows no transition for two consecutive `clk_b` cycles, the output moves to `clk_b`.
- R5: After an automatic failover, the output returns to `clk_a` once `clk_a` activity has been seen in at least two `clk_b` cycles.
- R6: With `mode[1]`=1 and `prim_is_b`=1, the block behaves as in manual mode. A stopped `clk_a` then neither changes the selection nor sets `loss_flag`.
- R7: The two source enables are never high together, `clk_out` stays low while neither is high, and no high or low phase of `clk_out` is shorter than the shorter half period of the two inputs.
- R8: `loss_flag` is set when an automatic failover occurs. It stays set until `loss_clr` is sampled high on a `clk_b` rising edge, and it is not cleared when the primary recovers.
- R9: `act_b` is 1 exactly when `clk_b` is the source driving `clk_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Reference input A |
| clk_b | input | 1 | Reference input B; clocks the watchdog |
| rst_n | input | 1 | Asynchronous active-low reset |
| prim_is_b | input | 1 | 0: A is primary; 1: B is primary |
| mode | input | 2 | Bit 1 = 0 manual, bit 1 = 1 automatic |
| sel_sec | input | 1 | Manual select: 0 primary, 1 secondary |
| loss_clr | input | 1 | Clears the loss flag, sampled on clk_b |
| clk_out | output | 1 | Selected output clock |
| act_b | output | 1 | High while clk_b drives the output |
| loss_flag | output | 1 | Sticky primary-loss indication |

## Verification
The bench stops `clk_a` in automatic mode. A design that waits for the dead clock to drop its own enable would leave `clk_out` stuck, and the run would end on the watchdog. The bench restarts `clk_a` and checks both the return to `clk_a` and that `loss_flag` is still set, which catches a flag that clears itself on recovery. The bench also stops `clk_a` while automatic mode is requested with `clk_b` primary, where a design that ignores the primary restriction would raise the flag. Throughout the run, a monitor measures every `clk_out` phase, so a switch that cuts a pulse short is caught as a runt.

// File: rtl/refclk_failover_mux.sv
module refclk_failover_mux #(
  parameter int IDLE_LIM = 2,
  parameter int ACT_LIM  = 2
) (
  input  logic       clk_a,
  input  logic       clk_b,
  input  logic       rst_n,
  input  logic       prim_is_b,
  input  logic [1:0] mode,
  input  logic       sel_sec,
  input  logic       loss_clr,
  output logic       clk_out,
  output logic       act_b,
  output logic       loss_flag
);
  localparam int CMAX = (IDLE_LIM > ACT_LIM) ? IDLE_LIM : ACT_LIM;
  localparam int CW = $clog2(CMAX + 1);
  localparam logic [CW-1:0] IDLE_TOP = CW'(IDLE_LIM);
  localparam logic [CW-1:0] IDLE_PRE = CW'(IDLE_LIM - 1);
  localparam logic [CW-1:0] ACT_PRE  = CW'(ACT_LIM - 1);

  logic auto_eff, use_sec, want_b, fail, a_kill;
  logic en_a, en_b;
  logic [1:0] a_s, b_s;
  logic tog_a;
  logic [2:0] tsy;
  logic chg, armed, lost_now;
  logic [CW-1:0] idle, act;

  assign auto_eff = mode[1] & ~prim_is_b;
  assign use_sec  = auto_eff ? fail : sel_sec;
  assign want_b   = prim_is_b ^ use_sec;
  assign a_kill   = ~rst_n | fail;

  always_ff @(posedge clk_a or posedge a_kill)
    if (a_kill) a_s <= '0;
    else        a_s <= {a_s[0], ~want_b & ~en_b};

  always_ff @(negedge clk_a or posedge a_kill)
    if (a_kill) en_a <= 1'b0;
    else        en_a <= a_s[1];

  always_ff @(posedge clk_b or negedge rst_n)
    if (!rst_n) b_s <= '0;
    else        b_s <= {b_s[0], want_b & ~en_a};

  always_ff @(negedge clk_b or negedge rst_n)
    if (!rst_n) en_b <= 1'b0;
    else        en_b <= b_s[1];

  assign clk_out = (clk_a & en_a) | (clk_b & en_b);
  assign act_b   = en_b;

  always_ff @(posedge clk_a or negedge rst_n)
    if (!rst_n) tog_a <= 1'b0;
    else        tog_a <= ~tog_a;

  always_ff @(posedge clk_b or negedge rst_n)
    if (!rst_n) tsy <= '0;
    else        tsy <= {tsy[1:0], tog_a};

  assign chg      = tsy[2] ^ tsy[1];
  assign lost_now = armed & ~chg & (idle == IDLE_PRE);

  always_ff @(posedge clk_b or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      idle      <= '0;
      act       <= '0;
      fail      <= 1'b0;
      loss_flag <= 1'b0;
    end else begin
      if (chg) armed <= 1'b1;
      if (chg) idle <= '0;
      else if (idle != IDLE_TOP) idle <= idle + 1'b1;

      if (!auto_eff) begin
        fail <= 1'b0;
        act  <= '0;
      end else if (!fail) begin
        act <= '0;
        if (lost_now) fail <= 1'b1;
      end else if (chg) begin
        if (act == ACT_PRE) begin
          fail <= 1'b0;
          act  <= '0;
        end else act <= act + 1'b1;
      end else if (idle == IDLE_PRE) act <= '0;

      if (auto_eff & ~fail & lost_now) loss_flag <= 1'b1;
      else if (loss_clr)               loss_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/refclk_failover_chk.sv
module refclk_failover_chk (
  input logic clk_b,
  input logic rst_n,
  input logic en_a,
  input logic en_b,
  input logic clk_out,
  input logic fail,
  input logic auto_eff,
  input logic loss_flag,
  input logic loss_clr
);
  p_break_before_make_r7: assert property (@(posedge clk_b) disable iff (!rst_n)
    !(en_a && en_b));
  p_gap_quiet_r7: assert property (@(posedge clk_b) disable iff (!rst_n)
    (!en_a && !en_b) |-> !clk_out);
  p_dead_primary_off_r4: assert property (@(posedge clk_b) disable iff (!rst_n)
    fail |-> !en_a);
  p_flag_on_fail_r8: assert property (@(posedge clk_b) disable iff (!rst_n)
    $rose(fail) |-> loss_flag);
  p_flag_sticky_r8: assert property (@(posedge clk_b) disable iff (!rst_n)
    (loss_flag && !loss_clr) |=> loss_flag);
  p_no_loss_manual_r6: assert property (@(posedge clk_b) disable iff (!rst_n)
    $rose(loss_flag) |-> $past(auto_eff));
endmodule

bind refclk_failover_mux refclk_failover_chk u_chk (
  .clk_b(clk_b), .rst_n(rst_n), .en_a(en_a), .en_b(en_b), .clk_out(clk_out),
  .fail(fail), .auto_eff(auto_eff), .loss_flag(loss_flag), .loss_clr(loss_clr)
);

// File: tb/refclk_failover_mux_tb.sv
`timescale 1ns/1ps
module refclk_failover_mux_tb;
  logic clk_a = 0, clk_b = 0, rst_n = 0;
  logic prim_is_b = 0, sel_sec = 0, loss_clr = 0;
  logic [1:0] mode = 2'b00;
  logic clk_out, act_b, loss_flag;
  logic a_run = 1;
  int checks = 0, errors = 0, runts = 0;
  realtime last_edge = 0;

  always #4 clk_a = a_run ? ~clk_a : 1'b0;
  always #5 clk_b = ~clk_b;

  refclk_failover_mux u_dut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .prim_is_b(prim_is_b),
    .mode(mode), .sel_sec(sel_sec), .loss_clr(loss_clr),
    .clk_out(clk_out), .act_b(act_b), .loss_flag(loss_flag)
  );

  always @(clk_out) begin
    if (rst_n && last_edge > 0 && ($realtime - last_edge) < 3.9) runts++;
    last_edge = $realtime;
  end

  function automatic bit exp_src(bit pb, bit [1:0] m, bit s, bit a_dead);
    bit ae = m[1] & ~pb;
    return pb ^ (ae ? a_dead : s);
  endfunction

  function automatic int exp_per(bit src_b);
    return src_b ? 100 : 80;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(posedge clk_b);
    #1;
  endtask

  task automatic period(output int tenths);
    realtime t0;
    @(posedge clk_out); t0 = $realtime;
    @(posedge clk_out);
    tenths = $rtoi(($realtime - t0) * 10.0 + 0.5);
    #1;
  endtask

  task automatic expect_src(bit src_b, string req);
    int p;
    period(p);
    chk(p == exp_per(src_b), req, "clk_out period x0.1ns", p, exp_per(src_b));
    chk(act_b == src_b, req, "act_b (R9)", act_b, src_b);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(8743);
    #43 rst_n = 1;
    settle(30);
    // R1 reset state
    chk(loss_flag == 0, "R1", "loss_flag after reset", loss_flag, 0);
    expect_src(0, "R1");

    // R3 manual select of secondary and back
    sel_sec = 1; settle(30); expect_src(1, "R3");
    sel_sec = 0; settle(30); expect_src(0, "R3");

    // R2 swap primary to B
    prim_is_b = 1; settle(30); expect_src(1, "R2");
    sel_sec = 1;   settle(30); expect_src(0, "R2");

    // R6 automatic requested with B primary: manual behaviour, stopped A ignored
    mode = 2'b10; sel_sec = 0; settle(30); expect_src(1, "R6");
    a_run = 0; settle(40);
    chk(loss_flag == 0, "R6", "loss_flag with B primary", loss_flag, 0);
    expect_src(1, "R6");
    a_run = 1; settle(20);

    // R4 automatic with A primary: select pin ignored while A runs
    prim_is_b = 0; sel_sec = 1; settle(40); expect_src(0, "R4");
    chk(loss_flag == 0, "R4", "no loss while A runs", loss_flag, 0);
    a_run = 0; settle(40);
    expect_src(1, "R4");
    chk(loss_flag == 1, "R8", "loss_flag set on failover", loss_flag, 1);

    // R5 revert, R8 sticky through recovery
    a_run = 1; settle(40);
    expect_src(0, "R5");
    chk(loss_flag == 1, "R8", "loss_flag kept after recovery", loss_flag, 1);
    @(negedge clk_b); loss_clr = 1; @(negedge clk_b); loss_clr = 0; #1;
    chk(loss_flag == 0, "R8", "loss_flag cleared", loss_flag, 0);

    // random configurations with both clocks running (R2 R3 R4 R6 R9)
    for (int i = 0; i < 24; i++) begin
      bit pb, s;
      bit [1:0] m;
      pb = 1'($urandom); s = 1'($urandom); m = 2'($urandom);
      prim_is_b = pb; sel_sec = s; mode = m;
      settle(30);
      expect_src(exp_src(pb, m, s, 1'b0), "R3");
    end
    chk(loss_flag == 0, "R6", "no loss in random phase", loss_flag, 0);
    chk(runts == 0, "R7", "runt phases on clk_out", runts, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule